// File: doc/BRIEF.md
# Reversible-Primitive Two's-Complement Comparator

This block decides the order of two W-bit two's-complement operands and drives exactly one of three flags: greater, less or equal. It is purely combinational and is assembled only from small primitives that each have as many outputs as inputs and map inputs to outputs one-to-one. Every constant line feeding a primitive is tied inside the block, and every primitive output that is not a result is collected on a single garbage bus. The block drives its primitive count and its constant-line count as ports, so the cost of an instance can be read off at integration time.

The structure is a ripple from the top bit down. A four-line comparator primitive handles the sign bits, with the greater and less roles swapped relative to an unsigned compare, so that a zero MSB beats a one MSB. Below it sit W-1 identical bit stages, one per remaining bit, running from bit W-2 down to bit 0. Each bit stage uses one three-line comparator primitive, two three-line controlled primitives and one three-line parity primitive. A stage passes on the decision it receives from above unless that decision is still "equal", in which case its own bit pair decides.

Top module: `rvc_signed_cmp`

## Requirements
- R1: Exactly one of `a_gt`, `a_lt`, `a_eq` is high for every operand pair, and every internal stage's flag triple is one-hot as well.
- R2: `a_gt` is high exactly when `op_a` is greater than `op_b` read as two's-complement, and `a_lt` is high exactly when it is smaller.
- R3: `a_eq` is high exactly when `op_a` and `op_b` are bit-for-bit identical.
- R4: When the MSBs differ, the operand whose MSB is 0 is greater, whatever the lower bits hold.
- R5: When the MSBs match, the highest lower bit position where the operands differ decides, and the operand with the 1 there is greater. Once a stage has decided greater or less, every stage below keeps that decision.
- R6: The controlled primitive maps input lines (a, b, c) on bits 0..2 to outputs (a, a XOR b, (a AND b) XOR c) on bits 0..2, and its eight output vectors are a permutation of its eight input vectors.
- R7: The parity primitive maps (a, b, c) to (a, b, a XOR b XOR c), and it is a permutation of its eight vectors.
- R8: The three-line comparator primitive maps (x, y, k) to (x, (NOT x AND y) XOR k, (x AND NOT y) XOR k), and it is a permutation of its eight vectors.
- R9: The four-line comparator primitive maps (x, y, k0, k1) to (x, (NOT x AND y) XOR k0, (x AND NOT y) XOR k0, x XOR y XOR k1), and it is a permutation of its sixteen vectors.
- R10: `gate_total` reads 4W-3, `ancilla_total` reads 2W, and the garbage bus is 4W-3 bits wide (29, 16 and 29 for W=8).
- R11: Garbage bit 0 carries `op_a[W-1]`. The stage for bit i (i from W-2 down to 0) owns garbage bits 4(W-1-i)-3 up to 4(W-1-i), holding in that order: `op_a[i]`; E XOR (a AND NOT b); E XOR (NOT a AND b); and E. Here a and b are bit i of each operand, and E is 1 exactly when every bit above i matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | W | First operand, two's-complement |
| op_b | input | W | Second operand, two's-complement |
| a_gt | output | 1 | op_a greater than op_b |
| a_lt | output | 1 | op_a less than op_b |
| a_eq | output | 1 | op_a equal to op_b |
| garbage | output | 4W-3 | Unused primitive outputs, gathered in stage order |
| gate_total | output | 16 | Number of primitives in the instance |
| ancilla_total | output | 16 | Number of constant input lines in the instance |

## Verification
The assertions rely on one property of the chain. The sign stage always emits a one-hot flag triple, and each bit stage's equal output is correct only while its incoming triple stays one-hot. This holds because the stage rebuilds "equal" as the complement of greater-or-less. The bench never drives internal lines. It presents every operand pair at the primary inputs, exhaustively at eight bits, and with random and extreme pairs at sixteen bits. As a result the incoming triple of every stage is always the output of a real upstream stage. The primitives are driven alone through every input vector to show that each one is a permutation.

// File: rtl/rvc_pkg.sv
`timescale 1ns/1ps
package rvc_pkg;

  // cost figures of one comparator instance, as a function of operand width
  function automatic int gate_count(input int w);
    return 4 * w - 3;
  endfunction

  function automatic int ancilla_count(input int w);
    return 2 * w;
  endfunction

  function automatic int garbage_width(input int w);
    return 4 * w - 3;
  endfunction

  // line maps: bit 0 is the first line of each primitive
  function automatic logic [2:0] map_peres(input logic [2:0] v);
    logic [2:0] r;
    r[0] = v[0];
    r[1] = v[0] ^ v[1];
    r[2] = (v[0] & v[1]) ^ v[2];
    return r;
  endfunction

  function automatic logic [2:0] map_parity(input logic [2:0] v);
    logic [2:0] r;
    r[0] = v[0];
    r[1] = v[1];
    r[2] = v[0] ^ v[1] ^ v[2];
    return r;
  endfunction

  function automatic logic [2:0] map_cmp3(input logic [2:0] v);
    logic [2:0] r;
    r[0] = v[0];
    r[1] = (~v[0] & v[1]) ^ v[2];
    r[2] = (v[0] & ~v[1]) ^ v[2];
    return r;
  endfunction

  function automatic logic [3:0] map_cmp4(input logic [3:0] v);
    logic [3:0] r;
    r[0] = v[0];
    r[1] = (~v[0] & v[1]) ^ v[2];
    r[2] = (v[0] & ~v[1]) ^ v[2];
    r[3] = v[0] ^ v[1] ^ v[3];
    return r;
  endfunction

endpackage

// File: rtl/rvc_prims.sv
`timescale 1ns/1ps
// controlled 3-line primitive: (a, b, c) -> (a, a^b, ab^c)
module rvc_peres (
  input  logic [2:0] din,
  output logic [2:0] dout
);
  assign dout = rvc_pkg::map_peres(din);
endmodule

// parity 3-line primitive: (a, b, c) -> (a, b, a^b^c)
module rvc_parity (
  input  logic [2:0] din,
  output logic [2:0] dout
);
  assign dout = rvc_pkg::map_parity(din);
endmodule

// 3-line bit comparator primitive
module rvc_cmp3 (
  input  logic [2:0] din,
  output logic [2:0] dout
);
  assign dout = rvc_pkg::map_cmp3(din);
endmodule

// 4-line bit comparator primitive with equality line
module rvc_cmp4 (
  input  logic [3:0] din,
  output logic [3:0] dout
);
  assign dout = rvc_pkg::map_cmp4(din);
endmodule

// File: rtl/rvc_bit_stage.sv
`timescale 1ns/1ps
// one lower-bit stage: four primitives, two constant lines, four garbage lines
module rvc_bit_stage (
  input  logic       g_i,
  input  logic       l_i,
  input  logic       e_i,
  input  logic       x,
  input  logic       y,
  output logic       g_o,
  output logic       l_o,
  output logic       e_o,
  output logic [3:0] junk
);
  localparam logic TIE_LO = 1'b0;
  localparam logic TIE_HI = 1'b1;

  logic [2:0] rc_o;
  logic [2:0] pg_o;
  logic [2:0] pl_o;
  logic [2:0] pe_o;
  logic       bit_gt;
  logic       bit_lt;

  // local bit order, constant line low
  rvc_cmp3 u_rc (.din({TIE_LO, y, x}), .dout(rc_o));
  assign bit_lt = rc_o[1];
  assign bit_gt = rc_o[2];

  // greater flag: carried-in greater toggled by (still-equal AND local greater)
  rvc_peres u_pg (.din({g_i, bit_gt, e_i}), .dout(pg_o));
  // less flag: same shape, reusing the pass-through of the equal line
  rvc_peres u_pl (.din({l_i, bit_lt, pg_o[0]}), .dout(pl_o));
  // equal flag rebuilt from a one-hot triple: NOT(greater XOR less)
  rvc_parity u_pe (.din({TIE_HI, pl_o[2], pg_o[2]}), .dout(pe_o));

  assign g_o  = pe_o[0];
  assign l_o  = pe_o[1];
  assign e_o  = pe_o[2];
  assign junk = {pl_o[0], pl_o[1], pg_o[1], rc_o[0]};
endmodule

// File: rtl/rvc_signed_cmp.sv
`timescale 1ns/1ps
module rvc_signed_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0]                          op_a,
  input  logic [W-1:0]                          op_b,
  output logic                                  a_gt,
  output logic                                  a_lt,
  output logic                                  a_eq,
  output logic [rvc_pkg::garbage_width(W)-1:0]  garbage,
  output logic [15:0]                           gate_total,
  output logic [15:0]                           ancilla_total
);
  import rvc_pkg::*;

  localparam int GATES = gate_count(W);
  localparam int ANCS  = ancilla_count(W);

  // decision after each level; index W-1 is the sign stage, index 0 the last bit
  logic [W-1:0] lvl_g;
  logic [W-1:0] lvl_l;
  logic [W-1:0] lvl_e;
  logic [3:0]   sgn_o;

  // sign stage: constants k0=0, k1=1; roles of greater and less swapped
  rvc_cmp4 u_sign (
    .din  ({1'b1, 1'b0, op_b[W-1], op_a[W-1]}),
    .dout (sgn_o)
  );
  assign lvl_g[W-1] = sgn_o[1];
  assign lvl_l[W-1] = sgn_o[2];
  assign lvl_e[W-1] = sgn_o[3];
  assign garbage[0] = sgn_o[0];

  generate
    for (genvar i = W - 2; i >= 0; i--) begin : g_bit
      localparam int BASE = 4 * (W - 1 - i) - 3;
      rvc_bit_stage u_stage (
        .g_i  (lvl_g[i+1]),
        .l_i  (lvl_l[i+1]),
        .e_i  (lvl_e[i+1]),
        .x    (op_a[i]),
        .y    (op_b[i]),
        .g_o  (lvl_g[i]),
        .l_o  (lvl_l[i]),
        .e_o  (lvl_e[i]),
        .junk (garbage[BASE +: 4])
      );
    end
  endgenerate

  assign a_gt          = lvl_g[0];
  assign a_lt          = lvl_l[0];
  assign a_eq          = lvl_e[0];
  assign gate_total    = 16'(GATES);
  assign ancilla_total = 16'(ANCS);
endmodule

// File: rtl/rvc_signed_cmp_chk.sv
`timescale 1ns/1ps
module rvc_signed_cmp_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         a_gt,
  input logic         a_lt,
  input logic         a_eq,
  input logic [W-1:0] lvl_g,
  input logic [W-1:0] lvl_l,
  input logic [W-1:0] lvl_e
);
  always_comb begin
    p_onehot_r1: assert ($onehot({a_gt, a_lt, a_eq}))
      else $error("result flags not one-hot");
    p_signed_gt_r2: assert (a_gt == ($signed(op_a) > $signed(op_b)))
      else $error("greater flag wrong");
    p_signed_lt_r2: assert (a_lt == ($signed(op_a) < $signed(op_b)))
      else $error("less flag wrong");
    p_equal_r3: assert (a_eq == (op_a == op_b))
      else $error("equal flag wrong");
    if (op_a[W-1] != op_b[W-1]) begin
      p_sign_rule_r4: assert (a_gt == op_b[W-1] && a_lt == op_a[W-1])
        else $error("sign bits not honoured");
    end
    for (int i = 0; i < W; i++) begin
      p_level_onehot_r1: assert ($onehot({lvl_g[i], lvl_l[i], lvl_e[i]}))
        else $error("stage triple not one-hot");
      p_prefix_eq_r5: assert (lvl_e[i] == (((op_a ^ op_b) >> i) == '0))
        else $error("stage equal does not track prefix");
    end
    for (int i = 1; i < W; i++) begin
      p_sticky_r5: assert ((!lvl_g[i] || lvl_g[i-1]) && (!lvl_l[i] || lvl_l[i-1]))
        else $error("decision lost down the chain");
    end
  end
endmodule

bind rvc_signed_cmp rvc_signed_cmp_chk #(.W(W)) u_chk (
  .op_a  (op_a),
  .op_b  (op_b),
  .a_gt  (a_gt),
  .a_lt  (a_lt),
  .a_eq  (a_eq),
  .lvl_g (lvl_g),
  .lvl_l (lvl_l),
  .lvl_e (lvl_e)
);

// File: tb/sim_rvc_signed_cmp.sv
`timescale 1ns/1ps
module sim_rvc_signed_cmp;
  localparam int WA = 8;
  localparam int WB = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [WA-1:0]     a8, b8;
  logic              gt8, lt8, eq8;
  logic [4*WA-4:0]   gb8;
  logic [15:0]       gc8, ac8;
  logic [WB-1:0]     a16, b16;
  logic              gt16, lt16, eq16;
  logic [4*WB-4:0]   gb16;
  logic [15:0]       gc16, ac16;

  rvc_signed_cmp #(.W(WA)) u0 (
    .op_a(a8), .op_b(b8), .a_gt(gt8), .a_lt(lt8), .a_eq(eq8),
    .garbage(gb8), .gate_total(gc8), .ancilla_total(ac8));
  rvc_signed_cmp #(.W(WB)) u1 (
    .op_a(a16), .op_b(b16), .a_gt(gt16), .a_lt(lt16), .a_eq(eq16),
    .garbage(gb16), .gate_total(gc16), .ancilla_total(ac16));

  logic [2:0] pp_i, pp_o, px_i, px_o, c3_i, c3_o;
  logic [3:0] c4_i, c4_o;
  rvc_peres  p_peres  (.din(pp_i), .dout(pp_o));
  rvc_parity p_parity (.din(px_i), .dout(px_o));
  rvc_cmp3   p_cmp3   (.din(c3_i), .dout(c3_o));
  rvc_cmp4   p_cmp4   (.din(c4_i), .dout(c4_o));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // expected garbage bus, built from the stated layout
  function automatic logic [63:0] ref_garb(input int w, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] g = '0;
    g[0] = a[w-1];
    for (int i = w - 2; i >= 0; i--) begin
      int base = 4 * (w - 1 - i) - 3;
      logic above_same = 1'b1;
      for (int j = i + 1; j < w; j++) if (a[j] != b[j]) above_same = 1'b0;
      g[base]   = a[i];
      g[base+1] = above_same ^ (a[i] && !b[i]);
      g[base+2] = above_same ^ (!a[i] && b[i]);
      g[base+3] = above_same;
    end
    return g;
  endfunction

  task automatic run8(input logic [WA-1:0] a, input logic [WA-1:0] b);
    int sa, sb;
    string tg;
    @(posedge clk);
    a8 = a; b8 = b;
    @(negedge clk);
    sa = (a[WA-1]) ? int'(a) - (1 << WA) : int'(a);
    sb = (b[WA-1]) ? int'(b) - (1 << WA) : int'(b);
    tg = (a[WA-1] != b[WA-1]) ? "R4 R2" : "R5 R2";
    chk({tg, " gt"}, 64'(gt8), 64'(sa > sb));
    chk({tg, " lt"}, 64'(lt8), 64'(sa < sb));
    chk("R3 eq", 64'(eq8), 64'(sa == sb));
    chk("R1 onehot", 64'(int'(gt8) + int'(lt8) + int'(eq8)), 64'd1);
    chk("R11 garbage w8", 64'(gb8), ref_garb(WA, 64'(a), 64'(b)));
  endtask

  task automatic run16(input logic [WB-1:0] a, input logic [WB-1:0] b);
    longint sa, sb;
    @(posedge clk);
    a16 = a; b16 = b;
    @(negedge clk);
    sa = (a[WB-1]) ? longint'(a) - 65536 : longint'(a);
    sb = (b[WB-1]) ? longint'(b) - 65536 : longint'(b);
    chk("R2 gt w16", 64'(gt16), 64'(sa > sb));
    chk("R2 lt w16", 64'(lt16), 64'(sa < sb));
    chk("R3 eq w16", 64'(eq16), 64'(sa == sb));
    chk("R1 onehot w16", 64'(int'(gt16) + int'(lt16) + int'(eq16)), 64'd1);
    chk("R11 garbage w16", 64'(gb16), ref_garb(WB, 64'(a), 64'(b)));
  endtask

  task automatic prims();
    logic [7:0]  s_pp, s_px, s_c3;
    logic [15:0] s_c4;
    s_pp = '0; s_px = '0; s_c3 = '0; s_c4 = '0;
    for (int v = 0; v < 8; v++) begin
      logic a, b, c;
      a = v[0]; b = v[1]; c = v[2];
      pp_i = v[2:0]; px_i = v[2:0]; c3_i = v[2:0];
      #1;
      chk("R6 peres map", 64'(pp_o), 64'({(a && b) != c, a != b, a}));
      chk("R7 parity map", 64'(px_o), 64'({(a + b + c) % 2 == 1, b, a}));
      chk("R8 cmp3 map", 64'(c3_o), 64'({(a && !b) != c, (!a && b) != c, a}));
      s_pp[pp_o] = 1'b1; s_px[px_o] = 1'b1; s_c3[c3_o] = 1'b1;
    end
    for (int v = 0; v < 16; v++) begin
      logic x, y, k0, k1;
      x = v[0]; y = v[1]; k0 = v[2]; k1 = v[3];
      c4_i = v[3:0];
      #1;
      chk("R9 cmp4 map", 64'(c4_o),
          64'({(x + y + k1) % 2 == 1, (x && !y) != k0, (!x && y) != k0, x}));
      s_c4[c4_o] = 1'b1;
    end
    chk("R6 peres permutation", 64'(s_pp), 64'hFF);
    chk("R7 parity permutation", 64'(s_px), 64'hFF);
    chk("R8 cmp3 permutation", 64'(s_c3), 64'hFF);
    chk("R9 cmp4 permutation", 64'(s_c4), 64'hFFFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    a8 = '0; b8 = '0; a16 = '0; b16 = '0;
    pp_i = '0; px_i = '0; c3_i = '0; c4_i = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // state after reset with zero operands
    chk("R3 idle eq", 64'({gt8, lt8, eq8}), 64'b001);
    chk("R10 gates w8", 64'(gc8), 64'd29);
    chk("R10 ancillas w8", 64'(ac8), 64'd16);
    chk("R10 garbage width w8", 64'($bits(gb8)), 64'd29);
    chk("R10 gates w16", 64'(gc16), 64'(4 * WB - 3));
    chk("R10 ancillas w16", 64'(ac16), 64'(2 * WB));
    chk("R10 garbage width w16", 64'($bits(gb16)), 64'(4 * WB - 3));
    prims();
    // every pair at eight bits
    for (int i = 0; i < 65536; i++) run8(i[15:8], i[7:0]);
    // extremes at sixteen bits
    run16(16'h8000, 16'h7FFF);
    run16(16'h7FFF, 16'h8000);
    run16(16'hFFFF, 16'h0000);
    run16(16'h0000, 16'hFFFF);
    run16(16'h8000, 16'h8000);
    run16(16'h1234, 16'h1235);
    for (int i = 0; i < 2000; i++) begin
      logic [WB-1:0] ra, rb;
      ra = WB'($urandom);
      rb = (i % 4 == 0) ? ra ^ WB'(1 << (i % WB)) : WB'($urandom);
      run16(ra, rb);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule